// File: doc/BRIEF.md
# Break-Protected Two-Step Status Flag Clear

This block holds a bank of peripheral status flags. A flag is set by a one-cycle set event and cleared by a two-step bus sequence. The first step is a read of the status register, which snapshots the flags that read as 1 at that moment. The second step is any read or write of the associated data register, which clears exactly those snapshotted flags. A flag that rises after the status read is not in the snapshot, so it survives the following data access.

A global break input marks a debug halt. While break is active and the break-clear-enable control bit is 0, bus accesses have no effect on the flags and none are lost. A sequence that was armed before break stays armed through the halt. The first data access after break ends then completes the clear. With the control bit set to 1, the clear sequence works during break as it does outside it, and a flag cleared that way stays cleared after break ends.

Top module: `brk_flag_guard`

## Requirements
- R1: After reset every flag reads 0, nothing is armed, and the break-clear-enable bit `brkClrEn` is 0.
- R2: A 1 on `setEvt[i]` makes `flags[i]` read 1 from the next cycle on. This holds even when a clearing data access targets the same bit in that cycle.
- R3: While `statusRd` is 1, `statusData` shows `flags` in the same cycle. Otherwise `statusData` is all zeros. An unprotected status read arms exactly the flags that are 1 in that cycle.
- R4: An unprotected data access (`dataAcc`=1) clears every armed flag on the next cycle and then disarms all bits.
- R5: A flag set after the arming status read is not cleared by the following data access.
- R6: A data access with no armed bits leaves all flags unchanged.
- R7: While `breakActive`=1 and `brkClrEn`=0, no flag falls. A data access in this state keeps the armed bits. A status read in this state neither arms nor disarms.
- R8: After break ends, a data access clears the flags armed before break, with no new status read.
- R9: With `brkClrEn`=1, the status read and the data access during break arm and clear as they do outside break.
- R10: A flag cleared during break stays 0 after `breakActive` falls, unless a new set event occurs.
- R11: When `brkClrEnWe`=1, `brkClrEn` takes the value of `brkClrEnD` on the next cycle. Otherwise it holds its value.
- R12: When an unprotected status read and data access occur in the same cycle, the access clears the previously armed bits. The newly armed set is then the flags that are 1 in that cycle and were not cleared by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| setEvt | input | NUM_FLAGS | Per-flag set events |
| statusRd | input | 1 | Bus read strobe of the status register (first step) |
| dataAcc | input | 1 | Bus read or write strobe of the data register (second step) |
| breakActive | input | 1 | Debug break mode is active |
| brkClrEnWe | input | 1 | Write strobe for the break-clear-enable bit |
| brkClrEnD | input | 1 | Value written to the break-clear-enable bit |
| brkClrEn | output | 1 | Current break-clear-enable bit |
| flags | output | NUM_FLAGS | Flag bits |
| statusData | output | NUM_FLAGS | Status register read data |

## Verification
The bench builds the block with NUM_FLAGS=4. With that width, random set events and bus strobes often produce the full-bank and empty-bank armed states. They also produce partial overlaps between a new set event and the armed snapshot. Long random runs of break, toggled with the enable bit, hold armed bits across several protected accesses. They also produce a release into an unprotected access, and simultaneous read-plus-access cycles.

// File: rtl/bfg_pkg.sv
package bfg_pkg;
  typedef struct packed {
    logic armLoad;   // take a fresh snapshot of the flags into the armed set
    logic clrFire;   // perform the second step on the armed set
  } bfgStrobe_t;
endpackage

// File: rtl/bfg_ctrl.sv
module bfg_ctrl
  import bfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       statusRd,
  input  logic       dataAcc,
  input  logic       breakActive,
  input  logic       enWe,
  input  logic       enD,
  output logic       enQ,
  output bfgStrobe_t strobes
);
  logic protectNow;

  always_ff @(posedge clk) begin
    if (!rstN)     enQ <= 1'b0;
    else if (enWe) enQ <= enD;
  end

  assign protectNow      = breakActive && !enQ;
  assign strobes.armLoad = statusRd && !protectNow;
  assign strobes.clrFire = dataAcc && !protectNow;

  assert_en_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !enWe |=> $stable(enQ));
  assert_en_load_R11: assert property (@(posedge clk) disable iff (!rstN)
    enWe |=> (enQ == $past(enD)));
endmodule

// File: rtl/bfg_dpath.sv
module bfg_dpath
  import bfg_pkg::*;
#(
  parameter int NUM_FLAGS = 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] setEvt,
  input  logic                 statusRd,
  input  bfgStrobe_t           strobes,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] statusData
);
  logic [NUM_FLAGS-1:0] armed;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gBit
    logic clrBit;
    logic flagNext;
    logic armNext;

    assign clrBit   = strobes.clrFire && armed[g];
    assign flagNext = (flags[g] && !clrBit) || setEvt[g];

    always_comb begin
      if (strobes.armLoad)      armNext = flags[g] && !clrBit;
      else if (strobes.clrFire) armNext = 1'b0;
      else                      armNext = armed[g];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flags[g] <= 1'b0;
        armed[g] <= 1'b0;
      end else begin
        flags[g] <= flagNext;
        armed[g] <= armNext;
      end
    end

    assert_set_wins_R2: assert property (@(posedge clk) disable iff (!rstN)
      setEvt[g] |=> flags[g]);
    assert_unarmed_keeps_R5: assert property (@(posedge clk) disable iff (!rstN)
      (flags[g] && !armed[g]) |=> flags[g]);
  end

  assign statusData = statusRd ? flags : '0;

  assert_disarm_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrFire && !strobes.armLoad) |=> (armed == '0));
endmodule

// File: rtl/brk_flag_guard.sv
module brk_flag_guard
  import bfg_pkg::*;
#(
  parameter int NUM_FLAGS = 8
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_FLAGS-1:0] setEvt,
  input  logic                 statusRd,
  input  logic                 dataAcc,
  input  logic                 breakActive,
  input  logic                 brkClrEnWe,
  input  logic                 brkClrEnD,
  output logic                 brkClrEn,
  output logic [NUM_FLAGS-1:0] flags,
  output logic [NUM_FLAGS-1:0] statusData
);
  bfgStrobe_t strobes;

  bfg_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .statusRd    (statusRd),
    .dataAcc     (dataAcc),
    .breakActive (breakActive),
    .enWe        (brkClrEnWe),
    .enD         (brkClrEnD),
    .enQ         (brkClrEn),
    .strobes     (strobes)
  );

  bfg_dpath #(.NUM_FLAGS(NUM_FLAGS)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .setEvt     (setEvt),
    .statusRd   (statusRd),
    .strobes    (strobes),
    .flags      (flags),
    .statusData (statusData)
  );

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rstN)
    (breakActive && !brkClrEn) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: tb/brk_flag_guard_tb_top.sv
module brk_flag_guard_tb_top;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NF-1:0] setEvt = '0;
  logic          statusRd = 1'b0;
  logic          dataAcc = 1'b0;
  logic          breakActive = 1'b0;
  logic          brkClrEnWe = 1'b0;
  logic          brkClrEnD = 1'b0;
  logic          brkClrEn;
  logic [NF-1:0] flags;
  logic [NF-1:0] statusData;

  int total = 0;
  int bad = 0;
  logic [NF-1:0] mFlags = '0;
  logic [NF-1:0] mArmed = '0;
  logic          mEn = 1'b0;
  string         lastTag = "R1";

  always #5 clk = ~clk;

  brk_flag_guard #(.NUM_FLAGS(NF)) dut_i (
    .clk(clk), .rstN(rstN), .setEvt(setEvt), .statusRd(statusRd),
    .dataAcc(dataAcc), .breakActive(breakActive), .brkClrEnWe(brkClrEnWe),
    .brkClrEnD(brkClrEnD), .brkClrEn(brkClrEn), .flags(flags),
    .statusData(statusData)
  );

  function automatic logic [NF-1:0] expStatus(logic rd, logic [NF-1:0] f);
    return rd ? f : '0;   // R3
  endfunction

  function automatic logic [2*NF:0] nextModel(
      logic [NF-1:0] f, logic [NF-1:0] a, logic en, logic [NF-1:0] s,
      logic rd, logic acc, logic brk);
    logic prot;
    logic [NF-1:0] clr;
    logic [NF-1:0] nf;
    logic [NF-1:0] na;
    prot = brk && !en;                       // R7
    clr  = (acc && !prot) ? a : '0;          // R4 R8 R9
    nf   = (f & ~clr) | s;                   // R2 R10
    if (rd && !prot)        na = f & ~clr;   // R3 R12
    else if (acc && !prot)  na = '0;         // R4
    else                    na = a;          // R7
    return {nf, na, 1'b0};
  endfunction

  task automatic check(string tag, string what, logic [NF-1:0] act, logic [NF-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic [NF-1:0] s, logic rd, logic acc,
                      logic brk, logic we, logic d);
    logic [2*NF:0] nx;
    @(negedge clk);
    check(lastTag, "flags", flags, mFlags);
    check("R11", "brkClrEn", {{(NF-1){1'b0}}, brkClrEn}, {{(NF-1){1'b0}}, mEn});
    setEvt = s; statusRd = rd; dataAcc = acc; breakActive = brk;
    brkClrEnWe = we; brkClrEnD = d;
    #1;
    check(tag, "statusData", statusData, expStatus(rd, mFlags));
    @(posedge clk);
    nx = nextModel(mFlags, mArmed, mEn, s, rd, acc, brk);
    mFlags = nx[2*NF:NF+1];
    mArmed = nx[NF:1];
    if (we) mEn = d;  // R11
    lastTag = tag;
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1: reset state seen by the first check
    step("R1", '0, 0, 0, 0, 0, 0);
    step("R2", 4'b0101, 0, 0, 0, 0, 0);
    step("R3", '0, 1, 0, 0, 0, 0);         // arms 0101
    step("R5", 4'b1000, 0, 0, 0, 0, 0);    // set after read
    step("R4", '0, 0, 1, 0, 0, 0);         // clears 0101, keeps 1000
    step("R6", '0, 0, 1, 0, 0, 0);         // nothing armed
    step("R6", '0, 0, 0, 0, 0, 0);
    step("R3", '0, 1, 0, 0, 0, 0);         // arms 1000
    step("R7", '0, 0, 1, 1, 0, 0);         // protected access
    step("R7", 4'b0001, 1, 0, 1, 0, 0);    // protected read, no re-arm
    step("R7", '0, 0, 1, 1, 0, 0);
    step("R8", '0, 0, 1, 0, 0, 0);         // clears 1000 only
    step("R8", '0, 0, 0, 0, 0, 0);
    step("R11", '0, 0, 0, 0, 1, 1);
    step("R9", 4'b0110, 0, 0, 1, 0, 0);
    step("R9", '0, 1, 0, 1, 0, 0);
    step("R9", '0, 0, 1, 1, 0, 0);
    step("R10", '0, 0, 0, 0, 0, 0);
    step("R10", '0, 0, 0, 0, 1, 0);
    step("R2", 4'b1010, 0, 0, 0, 0, 0);
    step("R2", '0, 1, 0, 0, 0, 0);
    step("R2", 4'b0010, 0, 1, 0, 0, 0);    // set wins over clear
    step("R12", 4'b0100, 1, 0, 0, 0, 0);
    step("R12", 4'b0001, 1, 1, 0, 0, 0);
    step("R12", '0, 0, 1, 0, 0, 0);
    step("R12", '0, 0, 0, 0, 0, 0);
    begin
      logic brkR = 1'b0;
      for (int i = 0; i < 4000; i++) begin
        logic [NF-1:0] s;
        if (($urandom % 12) == 0) brkR = ~brkR;
        for (int b = 0; b < NF; b++) s[b] = (($urandom % 6) == 0);
        step(brkR ? "R7" : "R4", s, ($urandom % 3) == 0, ($urandom % 3) == 0,
             brkR, ($urandom % 40) == 0, $urandom % 2);
      end
    end
    step("R10", '0, 0, 0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule